// File: doc/BRIEF.md
# Banked Vector Scratchpad with Conflict Serialization

This block is an on-chip scratchpad split into equal banks, each one 32-bit word wide, that serves a single vector access from a group of sixteen lanes issuing together. Every lane brings a word address, an enable and, on a write, a data word. The low address bits choose the bank and the upper bits choose the row inside it, so a run of consecutive words spreads across all banks.

Lanes whose addresses fall into one bank at different rows cannot be served at the same time. The block resolves these collisions on its own. On every pass each bank picks the lowest-numbered lane still waiting on it. All waiting lanes that name the very same word ride along in that pass as a broadcast. Lanes that lose wait for a later pass. A pass takes two clock cycles, which is the bank's cycle time. When nothing is left waiting, the block presents every lane's read data together with a one-cycle completion pulse and the number of passes it used. That pass count is the conflict degree of the access.

The requester hands over a request with a valid/ready handshake. Ready is high only while the block is idle, so a request offered at any other time is not taken.

Top module: `banked_scratchpad`

## Requirements
- R1: A word address maps to bank `addr % BANKS` (the low bits) and to row `addr / BANKS` inside that bank. Every word written can be read back unchanged at the same address, and the storage clears to zero on reset.
- R2: When all enabled lanes name different banks, the access uses exactly one pass. With 16 banks this holds for a lane stride of 1 or 3 words.
- R3: The reported pass count equals the largest number of different words that the enabled lanes name within any single bank. A stride of 2 gives 2 and a stride of 16 gives 16.
- R4: Lanes that name the same word never add a pass. That word is read once and returned to each of those lanes.
- R5: Each pass lasts two clock cycles. The done pulse is seen 2·n cycles after the accepting clock edge, where n is the pass count.
- R6: A request is taken only on a clock edge where req_valid and ready are both high. Ready is low from that edge until the done pulse has passed, and a request offered while ready is low changes neither storage nor results.
- R7: Done is high for exactly one cycle, and ready returns in the next cycle. rsp_rdata and rsp_passes keep their values until the next request is accepted.
- R8: When several enabled lanes write different data to one word, the highest-numbered of those lanes decides the stored value.
- R9: A lane whose enable is low never changes storage, and its rsp_rdata slot is zero.
- R10: A request with no lane enabled completes with a pass count of 0 and shows done in the first cycle after acceptance.
- R11: A write request returns zero on every rsp_rdata slot, and its pass count follows the same rule as a read.
- R12: After reset, ready is 1, done is 0, rsp_passes is 0 and rsp_rdata is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_lane_en | input | LANES | Per-lane enable |
| req_addr | input | LANES*AW | Per-lane word address; lane i uses bits [i*AW +: AW] |
| req_wdata | input | LANES*DATA_W | Per-lane write data; lane i uses bits [i*DATA_W +: DATA_W] |
| ready | output | 1 | Idle, so a request can be taken |
| done | output | 1 | One-cycle pulse when the request completes |
| rsp_rdata | output | LANES*DATA_W | Per-lane read data, held until the next acceptance |
| rsp_passes | output | PW | Passes used, which is the conflict degree |

## Verification
The pass count is tried with unit stride and stride 3, which must both stay at one pass. It is also tried with stride 2 and stride 16, which serialize to two and sixteen passes, so a design that merges too little or too much is exposed. An all-lanes-same-word read and a same-word write with different data per lane separate broadcast from conflict and check the highest-lane write rule. Partial lane masks, an empty mask and random clustered addresses exercise uneven per-bank loads. A final sweep over all of storage, together with a request offered while busy, confirms that nothing outside the enabled lanes and accepted requests changed any word.

// File: rtl/sps_pkg.sv
package sps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_SETTLE = 2'd2,
      ST_DONE   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/sps_bank.sv
// One bank: DEPTH rows of DATA_W bits, combinational read, clocked write.
module sps_bank #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int RW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RW-1:0]     row,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_en) begin
         cells[row] <= wr_data;
      end
   end

   assign rd_data = cells[row];
endmodule

// File: rtl/sps_bank_arb.sv
// Per-bank pass selection: the lowest pending lane on this bank wins; every
// pending lane naming the same word joins it. Write data: highest joined lane.
module sps_bank_arb #(
   parameter int LANES   = 16,
   parameter int AW      = 10,
   parameter int BW      = 4,
   parameter int DATA_W  = 32,
   parameter int BANK_ID = 0
) (
   input  logic [LANES-1:0]             pending,
   input  logic [LANES-1:0][AW-1:0]     lane_addr,
   input  logic [LANES-1:0][DATA_W-1:0] lane_wdata,
   output logic                         hit,
   output logic [AW-BW-1:0]             row,
   output logic [DATA_W-1:0]            wdata,
   output logic [LANES-1:0]             served
);
   localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

   logic [AW-1:0] win_addr;

   always_comb begin
      hit      = 1'b0;
      win_addr = '0;
      for (int l = 0; l < LANES; l++) begin
         if (!hit && pending[l] && (lane_addr[l][BW-1:0] == MY_BANK)) begin
            hit      = 1'b1;
            win_addr = lane_addr[l];
         end
      end
   end

   always_comb begin
      served = '0;
      wdata  = '0;
      for (int l = 0; l < LANES; l++) begin
         if (hit && pending[l] && (lane_addr[l] == win_addr)) begin
            served[l] = 1'b1;
            wdata     = lane_wdata[l];
         end
      end
   end

   assign row = win_addr[AW-1:BW];
endmodule

// File: rtl/sps_seq.sv
// Pass sequencer: holds the pending lane mask and counts passes.
module sps_seq
   import sps_pkg::*;
#(
   parameter int LANES = 16,
   localparam int PW   = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LANES-1:0] lane_en,
   input  logic [LANES-1:0] served,
   output logic             accept,
   output logic             issue,
   output logic             ready,
   output logic             done,
   output logic [LANES-1:0] pending,
   output logic [PW-1:0]    passes
);
   seq_state_e state;

   assign ready  = (state == ST_IDLE);
   assign done   = (state == ST_DONE);
   assign issue  = (state == ST_ISSUE);
   assign accept = ready && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pending <= '0;
         passes  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  pending <= lane_en;
                  passes  <= '0;
                  state   <= (|lane_en) ? ST_ISSUE : ST_DONE;
               end
            end
            ST_ISSUE: begin
               pending <= pending & ~served;
               passes  <= passes + PW'(1);
               state   <= ST_SETTLE;
            end
            ST_SETTLE: begin
               state <= (|pending) ? ST_ISSUE : ST_DONE;
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
   parameter int  LANES  = 16,
   parameter int  BANKS  = 16,
   parameter int  DEPTH  = 64,
   parameter int  DATA_W = 32,
   localparam int BW     = $clog2(BANKS),
   localparam int RW     = $clog2(DEPTH),
   localparam int AW     = BW + RW,
   localparam int PW     = $clog2(LANES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [LANES-1:0]          req_lane_en,
   input  logic [LANES*AW-1:0]       req_addr,
   input  logic [LANES*DATA_W-1:0]   req_wdata,
   output logic                      ready,
   output logic                      done,
   output logic [LANES*DATA_W-1:0]   rsp_rdata,
   output logic [PW-1:0]             rsp_passes
);
   initial begin
      assert (BANKS >= 2 && (1 << BW) == BANKS)
         else $error("BANKS must be a power of two, at least 2");
      assert (DEPTH >= 2 && (1 << RW) == DEPTH)
         else $error("DEPTH must be a power of two, at least 2");
      assert (LANES >= 1) else $error("LANES must be positive");
   end

   logic                         accept;
   logic                         issue;
   logic [LANES-1:0]             pending;
   logic [LANES-1:0]             pass_served;
   logic                         wr_q;
   logic [LANES-1:0][AW-1:0]     addr_q;
   logic [LANES-1:0][DATA_W-1:0] wdata_q;
   logic [LANES-1:0][DATA_W-1:0] rdata_q;

   logic [LANES-1:0]             bank_served [BANKS];
   logic [BANKS-1:0]             bank_hit;
   logic [RW-1:0]                bank_row   [BANKS];
   logic [DATA_W-1:0]            bank_wdata [BANKS];
   logic [DATA_W-1:0]            bank_rdata [BANKS];

   // Request capture at acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         wr_q    <= req_write;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   sps_seq #(.LANES(LANES)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .lane_en   (req_lane_en),
      .served    (pass_served),
      .accept    (accept),
      .issue     (issue),
      .ready     (ready),
      .done      (done),
      .pending   (pending),
      .passes    (rsp_passes)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      sps_bank_arb #(
         .LANES   (LANES),
         .AW      (AW),
         .BW      (BW),
         .DATA_W  (DATA_W),
         .BANK_ID (b)
      ) i_arb (
         .pending    (pending),
         .lane_addr  (addr_q),
         .lane_wdata (wdata_q),
         .hit        (bank_hit[b]),
         .row        (bank_row[b]),
         .wdata      (bank_wdata[b]),
         .served     (bank_served[b])
      );

      sps_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (issue && wr_q && bank_hit[b]),
         .row     (bank_row[b]),
         .wr_data (bank_wdata[b]),
         .rd_data (bank_rdata[b])
      );
   end

   always_comb begin
      pass_served = '0;
      for (int b = 0; b < BANKS; b++) pass_served |= bank_served[b];
   end

   // Per-lane result capture; cleared on acceptance so idle lanes read zero
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q[l] <= '0;
         end else if (accept) begin
            rdata_q[l] <= '0;
         end else if (issue && pass_served[l] && !wr_q) begin
            rdata_q[l] <= bank_rdata[addr_q[l][BW-1:0]];
         end
      end
   end

   assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sps_scratch_chk.sv
module sps_scratch_chk #(
   parameter int LANES  = 16,
   parameter int DATA_W = 32,
   parameter int PW     = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic [LANES-1:0]        req_lane_en,
   input logic                    ready,
   input logic                    done,
   input logic                    issue,
   input logic [LANES-1:0]        pending,
   input logic [LANES-1:0]        pass_served,
   input logic [LANES*DATA_W-1:0] rsp_rdata,
   input logic [PW-1:0]           rsp_passes
);
   a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> !ready);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ready);

   a_r7_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(rsp_rdata) && $stable(rsp_passes)));

   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !req_valid) |=> ($stable(rsp_rdata) && $stable(rsp_passes)));

   a_r3_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rsp_passes <= PW'(LANES)));

   a_r4_served_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ((pass_served & ~pending) == '0));

   a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (pass_served != '0));

   a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready && (req_lane_en == '0)) |=> (done && rsp_passes == '0));
endmodule

bind banked_scratchpad sps_scratch_chk #(
   .LANES  (LANES),
   .DATA_W (DATA_W),
   .PW     (PW)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_lane_en (req_lane_en),
   .ready       (ready),
   .done        (done),
   .issue       (issue),
   .pending     (pending),
   .pass_served (pass_served),
   .rsp_rdata   (rsp_rdata),
   .rsp_passes  (rsp_passes)
);

// File: tb/test_banked_scratchpad.sv
`timescale 1ns/1ps
module test_banked_scratchpad;
   localparam int LANES = 16;
   localparam int BANKS = 16;
   localparam int DEPTH = 64;
   localparam int DW    = 32;
   localparam int AW    = 10;
   localparam int PW    = 5;
   localparam int WORDS = BANKS * DEPTH;

   typedef struct packed {
      logic        wr;
      logic [15:0] en;
      logic [9:0]  base;
      logic [9:0]  stride;
   } pat_t;

   localparam int NPAT = 14;
   localparam pat_t PATS [NPAT] = '{
      '{1'b1, 16'hFFFF, 10'd0,   10'd1},   // R1 fill, R2 one pass, R11
      '{1'b1, 16'hFFFF, 10'd16,  10'd1},   // R1
      '{1'b1, 16'hFFFF, 10'd100, 10'd3},   // R2 stride 3 write
      '{1'b0, 16'hFFFF, 10'd0,   10'd1},   // R1 read back
      '{1'b0, 16'hFFFF, 10'd100, 10'd3},   // R2 stride 3 read
      '{1'b0, 16'hFFFF, 10'd0,   10'd2},   // R3 stride 2 -> 2 passes
      '{1'b1, 16'hFFFF, 10'd200, 10'd2},   // R3 write stride 2
      '{1'b0, 16'hFFFF, 10'd5,   10'd0},   // R4 broadcast
      '{1'b0, 16'hFFFF, 10'd7,   10'd16},  // R3 16-way
      '{1'b0, 16'h00FF, 10'd0,   10'd17},  // R9 partial mask
      '{1'b1, 16'hFFFF, 10'd300, 10'd0},   // R8 same-word write
      '{1'b0, 16'h0001, 10'd300, 10'd0},   // R8 readback via lane 0
      '{1'b0, 16'hA5A5, 10'd16,  10'd4},   // R9 sparse mask
      '{1'b0, 16'h0000, 10'd0,   10'd1}    // R10 empty
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  req_valid = 1'b0;
   logic                  req_write = 1'b0;
   logic [LANES-1:0]      req_lane_en = '0;
   logic [LANES*AW-1:0]   req_addr = '0;
   logic [LANES*DW-1:0]   req_wdata = '0;
   logic                  ready;
   logic                  done;
   logic [LANES*DW-1:0]   rsp_rdata;
   logic [PW-1:0]         rsp_passes;

   int n_checks = 0;
   int n_fail   = 0;
   logic [DW-1:0] model [WORDS];
   logic [31:0]   lfsr = 32'h1357_9BDF;

   always #4 clk = ~clk;   // 125 MHz

   banked_scratchpad #(.LANES(LANES), .BANKS(BANKS), .DEPTH(DEPTH), .DATA_W(DW)) i_banked_scratchpad (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_lane_en (req_lane_en),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .ready       (ready),
      .done        (done),
      .rsp_rdata   (rsp_rdata),
      .rsp_passes  (rsp_passes)
   );

   task automatic chk(input string req, input logic [LANES*DW-1:0] act, input logic [LANES*DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rand();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return lfsr;
   endfunction

   // Reference: pass count = max distinct words per bank over enabled lanes
   function automatic int exp_passes(input logic [LANES-1:0] en, input logic [LANES*AW-1:0] a);
      int best = 0;
      for (int b = 0; b < BANKS; b++) begin
         int cnt = 0;
         for (int l = 0; l < LANES; l++) begin
            logic [AW-1:0] al = a[l*AW +: AW];
            bit seen = 0;
            if (en[l] && (int'(al) % BANKS) == b) begin
               for (int j = 0; j < l; j++)
                  if (en[j] && a[j*AW +: AW] == al) seen = 1;
               if (!seen) cnt++;
            end
         end
         if (cnt > best) best = cnt;
      end
      return best;
   endfunction

   function automatic logic [LANES*DW-1:0] exp_rdata(input logic wr, input logic [LANES-1:0] en,
                                                     input logic [LANES*AW-1:0] a);
      logic [LANES*DW-1:0] r = '0;
      if (!wr)
         for (int l = 0; l < LANES; l++)
            if (en[l]) r[l*DW +: DW] = model[a[l*AW +: AW]];
      return r;
   endfunction

   task automatic model_write(input logic [LANES-1:0] en, input logic [LANES*AW-1:0] a,
                              input logic [LANES*DW-1:0] d);
      for (int l = 0; l < LANES; l++)   // ascending: highest lane lands last (R8)
         if (en[l]) model[a[l*AW +: AW]] = d[l*DW +: DW];
   endtask

   task automatic run_req(input logic wr, input logic [LANES-1:0] en, input logic [LANES*AW-1:0] a,
                          input logic [LANES*DW-1:0] d, input string tag);
      int ep = exp_passes(en, a);
      logic [LANES*DW-1:0] er = exp_rdata(wr, en, a);
      int lat = 0;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_lane_en = en; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      chk({tag, " R3 pass count"}, LANES*DW'(rsp_passes), LANES*DW'(ep));
      chk({tag, " R5 done latency"}, LANES*DW'(lat), LANES*DW'(2*ep));
      chk({tag, " R4/R9/R11 read data"}, rsp_rdata, er);
      if (wr) model_write(en, a, d);
   endtask

   task automatic build(input logic [9:0] base, input logic [9:0] stride, input int idx,
                        output logic [LANES*AW-1:0] a, output logic [LANES*DW-1:0] d);
      for (int l = 0; l < LANES; l++) begin
         a[l*AW +: AW] = AW'(int'(base) + int'(stride) * l);
         d[l*DW +: DW] = 32'h9E37_79B9 * (idx * 16 + l + 1);
      end
   endtask

   initial begin
      #1_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [LANES*AW-1:0] a;
      logic [LANES*DW-1:0] d;
      logic [LANES*DW-1:0] held;
      for (int i = 0; i < WORDS; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 ready", LANES*DW'(ready), LANES*DW'(1));
      chk("R12 done", LANES*DW'(done), '0);
      chk("R12 passes", LANES*DW'(rsp_passes), '0);
      chk("R12 rdata", rsp_rdata, '0);
      rst_n = 1'b1;

      for (int p = 0; p < NPAT; p++) begin
         build(PATS[p].base, PATS[p].stride, p, a, d);
         run_req(PATS[p].wr, PATS[p].en, a, d, $sformatf("pat%0d", p));
      end

      // R8: word 300 must hold lane 15's data
      chk("R8 highest lane wins", LANES*DW'(model[300]), LANES*DW'(32'h9E37_79B9 * (10 * 16 + 15 + 1)));

      // Random clustered traffic (R3, R4, R8, R9)
      for (int k = 0; k < 24; k++) begin
         logic [LANES-1:0] en = LANES'(next_rand());
         logic wr = next_rand()[0];
         for (int l = 0; l < LANES; l++) begin
            a[l*AW +: AW] = AW'(next_rand() % 48);
            d[l*DW +: DW] = next_rand();
         end
         run_req(wr, en, a, d, $sformatf("rand%0d", k));
      end

      // R6/R7: request offered while busy is ignored; outputs held after done
      build(10'd7, 10'd16, 0, a, d);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_lane_en = '1; req_addr = a;
      @(negedge clk);
      req_write = 1'b1; req_addr = {LANES{10'd900}}; req_wdata = {LANES{32'hDEAD_BEEF}};
      for (int c = 0; c < 4; c++) begin
         chk("R6 ready low while busy", LANES*DW'(ready), '0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk("R3 busy run passes", LANES*DW'(rsp_passes), LANES*DW'(16));
      chk("R4 busy run data", rsp_rdata, exp_rdata(1'b0, '1, a));
      held = rsp_rdata;
      @(negedge clk);
      chk("R7 done single cycle", LANES*DW'(done), '0);
      chk("R7 ready returns", LANES*DW'(ready), LANES*DW'(1));
      repeat (2) @(negedge clk);
      chk("R7 data held", rsp_rdata, held);
      build(10'd900, 10'd0, 0, a, d);
      run_req(1'b0, 16'h0001, a, d, "R6 ignored write");

      // R1: full sweep against the model
      for (int s = 0; s < WORDS / LANES; s++) begin
         build(10'(s * LANES), 10'd1, 0, a, d);
         run_req(1'b0, '1, a, d, $sformatf("R1 sweep%0d", s));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule